// File: doc/BRIEF.md
# Converter Mode and Calibration Sequencer

This block is the digital controller placed between a bus-visible control register and a sigma-delta converter core. Software writes a 16-bit control word. The low three bits pick one of eight operating modes, and the next two bits pick a power profile. The sequencer counts the core's valid output words until a result has settled, then acts on that result. In conversion modes it corrects the raw word with the stored offset and gain and publishes it. In calibration modes it captures the raw word into the offset or gain register.

Single conversions and every kind of calibration fall back to idle by themselves once the settled word has been used. A published result stays frozen until software clears its ready flag. Results that arrive while the flag is still set are discarded, and a sticky overrun bit records the loss. Any write to the control register also emits a one-cycle reset pulse to the secondary channel's sequencer.

Top module: `cnv_sequencer`

## Requirements
- R1: After reset, the control register reads 0x8000, the mode is power-down (`core_on`=0), offset reads 0, gain reads 0x800000 and status reads 0.
- R2: Power field ctrl[4:3]: 01 and 11 raise `low_pwr`, only 11 raises `amp_off`, and 00 and 10 both leave the two outputs low.
- R3: Mode 010 (single) publishes a result on the 2nd valid sample with `chop_en`=0 or on the 3rd with `chop_en`=1, then the mode field reads 011 (idle, `core_hold`=1).
- R4: Mode 001 (continuous) publishes the settled sample and then every following sample, and stays in mode 001.
- R5: Published data equals floor((raw - offset) * gain / 2^23), where gain is unsigned Q1.23 (0x800000 = 1.0), saturated to the signed 24-bit range.
- R6: Modes 100 (self offset) and 110 (system zero-scale) store the settled raw sample into the offset register, return to idle, set status bits 0 and 1, and leave the data register unchanged.
- R7: Mode 101 (self gain) needs twice the settle count and stores the settled raw sample into the gain register. Mode 111 (system full-scale) uses the plain settle count and also writes the gain register. Both return to idle.
- R8: A write of mode 101 while `unity_gain` is 0 is refused: the mode field reads 011 and no status bit is set.
- R9: While status bit 0 (data ready) is set, new results are dropped, the data register holds its value and status bit 2 (overrun) is set. Writing ones to status bits clears them.
- R10: Every control-register write produces `aux_rst`=1 for exactly the following cycle.
- R11: In modes 000 and 011, samples are ignored and no status bit changes.
- R12: A control-register write restarts the settle count.
- R13: Register addresses are 0 control, 1 status, 2 data, 3 offset and 4 gain. `rd_data` shows the addressed register one cycle after `rd_addr`, with data and offset sign-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Registered read data |
| smp_valid | input | 1 | Raw sample strobe from converter core |
| smp_data | input | 24 | Raw signed sample |
| chop_en | input | 1 | Chopping enabled (longer settle) |
| unity_gain | input | 1 | Amplifier gain is 1 |
| core_on | output | 1 | Converter powered (mode not 000) |
| core_hold | output | 1 | Converter held in idle (mode 011) |
| low_pwr | output | 1 | Low-power profile selected |
| amp_off | output | 1 | Amplifier disabled |
| aux_rst | output | 1 | Secondary-channel reset pulse |

## Verification
The assertions assume `unity_gain` and `chop_en` stay constant while a calibration or conversion is counting. They also assume that a sample strobe and a control write in the same cycle resolve in favour of the write. The stimulus changes the chop and gain inputs only between sequences, and it drives samples only on cycles with no bus write. Status clears are issued only after the result under test has been read.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [2:0] {
    M_OFF    = 3'd0,
    M_CONT   = 3'd1,
    M_SINGLE = 3'd2,
    M_IDLE   = 3'd3,
    M_SOFF   = 3'd4,
    M_SGAIN  = 3'd5,
    M_ZERO   = 3'd6,
    M_FULL   = 3'd7
  } op_mode_e;

  localparam int          AW       = 3;
  localparam int          BW       = 32;
  localparam logic [2:0]  A_CTRL   = 3'd0;
  localparam logic [2:0]  A_STAT   = 3'd1;
  localparam logic [2:0]  A_DATA   = 3'd2;
  localparam logic [2:0]  A_OFFS   = 3'd3;
  localparam logic [2:0]  A_GAIN   = 3'd4;
  localparam logic [15:0] CTRL_RST = 16'h8000;
endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int SETTLE_PLAIN = 2,
  parameter int SETTLE_CHOP  = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ctrl_we,
  input  logic [15:0] ctrl_wdata,
  input  logic        unity_gain,
  input  logic        chop_en,
  input  logic        smp_valid,
  output logic [15:0] ctrl_q,
  output logic        conv_ev,
  output logic        zero_ev,
  output logic        span_ev
);
  localparam int CW = $clog2(2 * SETTLE_CHOP + 1);

  op_mode_e       mode, wmode;
  logic [CW-1:0]  base, target, cnt;
  logic           busy, oneshot, hit;

  assign mode    = op_mode_e'(ctrl_q[2:0]);
  assign wmode   = op_mode_e'(ctrl_wdata[2:0]);
  assign base    = chop_en ? CW'(SETTLE_CHOP) : CW'(SETTLE_PLAIN);
  assign target  = (mode == M_SGAIN) ? CW'(base << 1) : base;
  assign busy    = (mode != M_OFF) && (mode != M_IDLE);
  assign oneshot = busy && (mode != M_CONT);
  // write beats a sample in the same cycle
  assign hit     = !ctrl_we && smp_valid && busy && (cnt >= target - 1'b1);

  assign conv_ev = hit && (mode == M_CONT || mode == M_SINGLE);
  assign zero_ev = hit && (mode == M_SOFF || mode == M_ZERO);
  assign span_ev = hit && (mode == M_SGAIN || mode == M_FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RST;
      cnt    <= '0;
    end else if (ctrl_we) begin
      cnt <= '0;
      if (wmode == M_SGAIN && !unity_gain)
        ctrl_q <= {ctrl_wdata[15:3], M_IDLE};
      else
        ctrl_q <= ctrl_wdata;
    end else if (hit) begin
      if (oneshot) begin
        ctrl_q[2:0] <= M_IDLE;
        cnt         <= '0;
      end
    end else if (smp_valid && busy) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/seq_trim.sv
module seq_trim #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         off_we,
  input  logic         gain_we,
  input  logic [W-1:0] wdata,
  input  logic         zero_ev,
  input  logic         span_ev,
  input  logic [W-1:0] smp_data,
  output logic [W-1:0] off_q,
  output logic [W-1:0] gain_q,
  output logic [W-1:0] corr
);
  localparam int PW = 2 * W + 2;
  localparam logic signed [PW-1:0] PMAX = {{(W+3){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [PW-1:0] NMIN = {{(W+3){1'b1}}, {(W-1){1'b0}}};
  localparam logic [W-1:0] UNITY = {1'b1, {(W-1){1'b0}}};

  logic signed [W:0]    diff, gext;
  logic signed [PW-1:0] prod, shf;

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q  <= '0;
      gain_q <= UNITY;
    end else begin
      if (off_we)       off_q  <= wdata;
      else if (zero_ev) off_q  <= smp_data;
      if (gain_we)      gain_q <= wdata;
      else if (span_ev) gain_q <= smp_data;
    end
  end

  always_comb begin
    diff = $signed({smp_data[W-1], smp_data}) - $signed({off_q[W-1], off_q});
    gext = $signed({1'b0, gain_q});
    prod = PW'(diff) * PW'(gext);
    shf  = prod >>> (W - 1);
    if (shf > PMAX)      corr = {1'b0, {(W-1){1'b1}}};
    else if (shf < NMIN) corr = {1'b1, {(W-1){1'b0}}};
    else                 corr = shf[W-1:0];
  end
endmodule

// File: rtl/seq_flags.sv
module seq_flags #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         conv_ev,
  input  logic         cal_ev,
  input  logic         clr_we,
  input  logic [2:0]   clr_bits,
  input  logic [W-1:0] corr,
  output logic [W-1:0] data_q,
  output logic [2:0]   stat_q
);
  logic [2:0] clr;
  assign clr = clr_we ? clr_bits : 3'b000;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      stat_q <= '0;
    end else begin
      if (conv_ev && !stat_q[0]) data_q <= corr;
      stat_q[0] <= (stat_q[0] & ~clr[0]) | (conv_ev & ~stat_q[0]) | cal_ev;
      stat_q[1] <= (stat_q[1] & ~clr[1]) | cal_ev;
      stat_q[2] <= (stat_q[2] & ~clr[2]) | (conv_ev & stat_q[0]);
    end
  end
endmodule

// File: rtl/cnv_sequencer.sv
module cnv_sequencer
  import seq_pkg::*;
#(
  parameter int W            = 24,
  parameter int SETTLE_PLAIN = 2,
  parameter int SETTLE_CHOP  = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [BW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [BW-1:0] rd_data,
  input  logic          smp_valid,
  input  logic [W-1:0]  smp_data,
  input  logic          chop_en,
  input  logic          unity_gain,
  output logic          core_on,
  output logic          core_hold,
  output logic          low_pwr,
  output logic          amp_off,
  output logic          aux_rst
);
  localparam int XW = BW - W;

  logic [15:0]  ctrl_q;
  logic [W-1:0] off_q, gain_q, corr, data_q;
  logic [2:0]   stat_q;
  logic         conv_ev, zero_ev, span_ev;
  logic         ctrl_we, stat_we, off_we, gain_we;

  assign ctrl_we = wr_en && (wr_addr == A_CTRL);
  assign stat_we = wr_en && (wr_addr == A_STAT);
  assign off_we  = wr_en && (wr_addr == A_OFFS);
  assign gain_we = wr_en && (wr_addr == A_GAIN);

  seq_ctrl #(.SETTLE_PLAIN(SETTLE_PLAIN), .SETTLE_CHOP(SETTLE_CHOP)) u_ctrl (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(wr_data[15:0]),
    .unity_gain(unity_gain), .chop_en(chop_en), .smp_valid(smp_valid),
    .ctrl_q(ctrl_q), .conv_ev(conv_ev), .zero_ev(zero_ev), .span_ev(span_ev)
  );

  seq_trim #(.W(W)) u_trim (
    .clk(clk), .rst(rst), .off_we(off_we), .gain_we(gain_we),
    .wdata(wr_data[W-1:0]), .zero_ev(zero_ev), .span_ev(span_ev),
    .smp_data(smp_data), .off_q(off_q), .gain_q(gain_q), .corr(corr)
  );

  seq_flags #(.W(W)) u_flags (
    .clk(clk), .rst(rst), .conv_ev(conv_ev), .cal_ev(zero_ev | span_ev),
    .clr_we(stat_we), .clr_bits(wr_data[2:0]), .corr(corr),
    .data_q(data_q), .stat_q(stat_q)
  );

  assign core_on   = (ctrl_q[2:0] != M_OFF);
  assign core_hold = (ctrl_q[2:0] == M_IDLE);
  assign low_pwr   = ctrl_q[3];
  assign amp_off   = ctrl_q[4] & ctrl_q[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      aux_rst <= 1'b0;
      rd_data <= '0;
    end else begin
      aux_rst <= ctrl_we;
      case (rd_addr)
        A_CTRL:  rd_data <= {{(BW-16){1'b0}}, ctrl_q};
        A_STAT:  rd_data <= {{(BW-3){1'b0}}, stat_q};
        A_DATA:  rd_data <= {{XW{data_q[W-1]}}, data_q};
        A_OFFS:  rd_data <= {{XW{off_q[W-1]}}, off_q};
        A_GAIN:  rd_data <= {{XW{1'b0}}, gain_q};
        default: rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/seq_check.sv
module seq_check
  import seq_pkg::*;
#(
  parameter int W = 24
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [BW-1:0] wr_data,
  input logic          unity_gain,
  input logic          aux_rst,
  input logic          low_pwr,
  input logic          amp_off,
  input logic [15:0]   ctrl_q,
  input logic [2:0]    stat_q,
  input logic [W-1:0]  data_q
);
  logic cw;
  assign cw = wr_en && (wr_addr == A_CTRL);

  p_aux_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    cw |=> aux_rst);
  p_aux_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !cw |=> !aux_rst);
  p_hold_data_r9: assert property (@(posedge clk) disable iff (rst)
    stat_q[0] |=> $stable(data_q));
  p_gain_refused_r8: assert property (@(posedge clk) disable iff (rst)
    (cw && wr_data[2:0] == 3'b101 && !unity_gain) |=> (ctrl_q[2:0] == 3'b011));
  p_cal_idle_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_q[1]) |-> (ctrl_q[2:0] == 3'b011));
  p_amp_lowpwr_r2: assert property (@(posedge clk) disable iff (rst)
    amp_off |-> low_pwr);
endmodule

bind cnv_sequencer seq_check #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .unity_gain(unity_gain), .aux_rst(aux_rst), .low_pwr(low_pwr),
  .amp_off(amp_off), .ctrl_q(ctrl_q), .stat_q(stat_q), .data_q(data_q)
);

// File: tb/cnv_sequencer_test.sv
module cnv_sequencer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        smp_valid = 1'b0;
  logic [23:0] smp_data = '0;
  logic        chop_en = 1'b0;
  logic        unity_gain = 1'b1;
  logic        core_on, core_hold, low_pwr, amp_off, aux_rst;
  int          n_chk = 0;
  int          n_bad = 0;
  logic [31:0] v;

  always #5 clk = ~clk;

  cnv_sequencer uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .smp_valid(smp_valid),
    .smp_data(smp_data), .chop_en(chop_en), .unity_gain(unity_gain),
    .core_on(core_on), .core_hold(core_hold), .low_pwr(low_pwr),
    .amp_off(amp_off), .aux_rst(aux_rst)
  );

  // raw, offset, gain, expected corrected result
  localparam logic [95:0] VEC [8] = '{
    {24'h000100, 24'h000000, 24'h800000, 24'h000100},
    {24'h001000, 24'h000100, 24'h400000, 24'h000780},
    {24'h7FFFFF, 24'hFFFFFF, 24'h800000, 24'h7FFFFF},
    {24'h800000, 24'h000001, 24'h800000, 24'h800000},
    {24'hFFFF00, 24'h000000, 24'hC00000, 24'hFFFE80},
    {24'h000003, 24'h000000, 24'h400000, 24'h000001},
    {24'hFFFFFD, 24'h000000, 24'h400000, 24'hFFFFFE},
    {24'h200000, 24'h000000, 24'hFFFFFF, 24'h3FFFFF}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic smp(input logic [23:0] x);
    smp_valid = 1'b1; smp_data = x;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state, R13 map
    rd(3'd0, v); chk("R1 ctrl", v, 32'h8000);
    chk("R1 core_on", {31'b0, core_on}, 32'h0);
    rd(3'd3, v); chk("R1 offset", v, 32'h0);
    rd(3'd4, v); chk("R1 gain", v, 32'h800000);
    rd(3'd1, v); chk("R1 status", v, 32'h0);

    // R2 power field
    for (int p = 0; p < 4; p++) begin
      wr(3'd0, 32'h3 | (p << 3));
      chk("R2 low_pwr", {31'b0, low_pwr}, {31'b0, (p == 1 || p == 3)});
      chk("R2 amp_off", {31'b0, amp_off}, {31'b0, (p == 3)});
    end

    // R10 aux reset pulse
    wr(3'd0, 32'h3);
    chk("R10 pulse", {31'b0, aux_rst}, 32'h1);
    @(negedge clk);
    chk("R10 single", {31'b0, aux_rst}, 32'h0);

    // R5 correction table with single conversions (R3, chop off)
    for (int i = 0; i < 8; i++) begin
      wr(3'd3, {8'h0, VEC[i][71:48]});
      wr(3'd4, {8'h0, VEC[i][47:24]});
      wr(3'd0, 32'h2);
      smp(VEC[i][95:72]);
      smp(VEC[i][95:72]);
      rd(3'd2, v); chk("R5 data", v, {{8{VEC[i][23]}}, VEC[i][23:0]});
      wr(3'd1, 32'h7);
    end
    wr(3'd3, 32'h0); wr(3'd4, 32'h800000);

    // R3 chop on: three samples, then idle
    chop_en = 1'b1;
    wr(3'd0, 32'h2);
    smp(24'h11); smp(24'h22);
    rd(3'd1, v); chk("R3 not yet", v, 32'h0);
    smp(24'h33);
    rd(3'd1, v); chk("R3 ready", v, 32'h1);
    rd(3'd2, v); chk("R3 data", v, 32'h33);
    rd(3'd0, v); chk("R3 idle", v, 32'h3);
    chk("R3 hold", {31'b0, core_hold}, 32'h1);
    wr(3'd1, 32'h7);
    chop_en = 1'b0;

    // R12 restart on control write
    wr(3'd0, 32'h2);
    smp(24'h44);
    wr(3'd0, 32'h2);
    smp(24'h55);
    rd(3'd1, v); chk("R12 restarted", v, 32'h0);
    smp(24'h66);
    rd(3'd2, v); chk("R12 data", v, 32'h66);
    wr(3'd1, 32'h7);

    // R4 continuous and R9 overrun and hold
    wr(3'd0, 32'h1);
    smp(24'h5); smp(24'h6);
    rd(3'd2, v); chk("R4 first", v, 32'h6);
    smp(24'h7);
    rd(3'd2, v); chk("R9 held", v, 32'h6);
    rd(3'd1, v); chk("R9 overrun", v, 32'h5);
    wr(3'd1, 32'h7);
    rd(3'd1, v); chk("R9 cleared", v, 32'h0);
    smp(24'h8);
    rd(3'd2, v); chk("R4 next", v, 32'h8);
    rd(3'd0, v); chk("R4 stays", v, 32'h1);
    wr(3'd1, 32'h7);

    // R11 powerdown and idle ignore samples
    wr(3'd0, 32'h0);
    smp(24'h9); smp(24'h9); smp(24'h9);
    wr(3'd0, 32'h3);
    smp(24'h9); smp(24'h9); smp(24'h9);
    rd(3'd1, v); chk("R11 status", v, 32'h0);
    rd(3'd2, v); chk("R11 data", v, 32'h8);

    // R6 self offset
    wr(3'd0, 32'h4);
    smp(24'h10); smp(24'h20);
    rd(3'd3, v); chk("R6 offset", v, 32'h20);
    rd(3'd1, v); chk("R6 status", v, 32'h3);
    rd(3'd0, v); chk("R6 idle", v, 32'h3);
    rd(3'd2, v); chk("R6 data kept", v, 32'h8);
    wr(3'd1, 32'h7);

    // R6 system zero-scale
    wr(3'd0, 32'h6);
    smp(24'h1); smp(24'hFFFFF0);
    rd(3'd3, v); chk("R6 zero", v, 32'hFFFFFFF0);
    wr(3'd1, 32'h7);

    // R7 self gain: four samples with chop off
    wr(3'd0, 32'h5);
    smp(24'h1); smp(24'h2); smp(24'h3);
    rd(3'd0, v); chk("R7 stage two", v, 32'h5);
    smp(24'h600000);
    rd(3'd4, v); chk("R7 gain", v, 32'h600000);
    rd(3'd0, v); chk("R7 idle", v, 32'h3);
    rd(3'd1, v); chk("R7 status", v, 32'h3);
    wr(3'd1, 32'h7);

    // R7 system full-scale
    wr(3'd0, 32'h7);
    smp(24'h1); smp(24'h700000);
    rd(3'd4, v); chk("R7 full", v, 32'h700000);
    wr(3'd1, 32'h7);

    // R8 refused self gain
    unity_gain = 1'b0;
    wr(3'd0, 32'h5);
    rd(3'd0, v); chk("R8 mode", v, 32'h3);
    smp(24'h1); smp(24'h2); smp(24'h3); smp(24'h4);
    rd(3'd1, v); chk("R8 status", v, 32'h0);
    rd(3'd4, v); chk("R8 gain kept", v, 32'h700000);
    unity_gain = 1'b1;

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule